// File: doc/BRIEF.md
# Status Register Write-Protect Unit

This unit holds the protection state of a serial byte-addressed memory and decides, byte by byte, whether a write may land. A serial command engine feeds it single-cycle events: write-enable set, write-enable clear, a status-register write carrying its data byte, and the close of any frame that carried a write command. It also feeds the byte address currently being written. The active-low hardware protect pin `wp_n` comes straight from the package. The unit returns two grants, one for memory bytes and one for status-register updates, and the status byte used for status readback.

Protection has three tiers. The write-enable flag must be set for any write, and it drops when every write frame closes. Two block-protect bits fence off the top quarter, the top half or the whole array. A protect-enable bit lets the hardware pin lock the status register, and without it the pin has no effect. The protect-enable and block-protect bits are plain registers with parameterised reset values.

Top module: `sr_wp_unit`

## Requirements
- R1: `status_byte` bit 7 is the protect-enable bit, bits 3 and 2 are the block-protect code (bit 3 the upper bit), bit 1 is the write-enable flag, and bits 6, 5, 4 and 0 always read 0 whatever a status write carries.
- R2: After reset the write-enable flag is 0. `ev_wren` sets it and `ev_wrdi` clears it on the next clock edge. Bit 1 of an accepted status write never changes it.
- R3: `ev_wr_close` clears the write-enable flag on the next edge, with priority over `ev_wrdi` and `ev_wren` in the same cycle. `ev_wrdi` takes priority over `ev_wren`.
- R4: Block-protect codes, with the default 11-bit address: 00 protects nothing, 01 protects 600h-7FFh, 10 protects 400h-7FFh, and 11 protects 000h-7FFh.
- R5: `mem_wr_ok` is 1 exactly when the write-enable flag is 1 and `byte_addr` lies outside the protected range. `wp_n` has no effect on it.
- R6: `sr_wr_ok` is 1 exactly when the write-enable flag is 1 and not both protect-enable=1 and `wp_n`=0. An `ev_wrsr` seen while `sr_wr_ok`=1 loads bits 7, 3 and 2 of `wrsr_data` on that edge. A rejected one leaves them unchanged.
- R7: Reset loads protect-enable and block-protect from parameters (defaults 0 and 00), so `status_byte` reads 00h during and after reset.
- R8: `mem_wr_ok` follows `byte_addr` within the same cycle, so a sequential write that wraps from 7FFh to 000h is refused only on protected bytes.
- R9: With block-protect 11, protect-enable 1 and `wp_n`=0, no sequence of events gives `mem_wr_ok`=1 or changes protect-enable or block-protect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_wren | input | 1 | Write-enable set event |
| ev_wrdi | input | 1 | Write-enable clear event |
| ev_wrsr | input | 1 | Status-register write event, data on `wrsr_data` |
| wrsr_data | input | 8 | Data byte of the status write |
| ev_wr_close | input | 1 | End of a frame that carried a memory or status write |
| byte_addr | input | ADDR_W | Address of the byte being written |
| wp_n | input | 1 | Hardware protect pin, active low |
| mem_wr_ok | output | 1 | Grant for the current memory byte |
| sr_wr_ok | output | 1 | Grant for a status update |
| status_byte | output | 8 | Status byte for readback |

## Verification
The bench targets the edges of each protected range: 5FFh against 600h, 3FFh against 400h, and a wrap from 7FFh to 000h. An off-by-one in the range compare would grant or refuse the wrong byte there. It writes a status byte with every bit set, so a design that stores the fixed-zero bits or lets bit 1 drive the write-enable flag shows a wrong readback. It fires close, clear and set events in the same cycle, where a wrong priority leaves the flag set. It also drives `wp_n` low both with protect-enable clear and with it set. A design that ties the pin to memory writes, or that always obeys the pin, then shows a wrong grant.

// File: rtl/sr_wp_pkg.sv
package sr_wp_pkg;
  localparam int SR_W     = 8;
  localparam int WPEN_BIT = 7;
  localparam int BP_HI    = 3;
  localparam int BP_LO    = 2;
  localparam int WEL_BIT  = 1;
  // bits a status write may change (protect-enable and block-protect)
  localparam logic [SR_W-1:0] SR_WR_MASK = 8'b1000_1100;

  typedef enum logic [1:0] {
    BP_NONE    = 2'b00,
    BP_QUARTER = 2'b01,
    BP_HALF    = 2'b10,
    BP_ALL     = 2'b11
  } bp_code_e;
endpackage

// File: rtl/sr_wp_range.sv
module sr_wp_range
  import sr_wp_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic [1:0]        bp,
  input  logic [ADDR_W-1:0] addr,
  output logic              locked
);
  localparam int SHIFT = ADDR_W - 2;

  logic [1:0]        quarter_idx;
  logic [ADDR_W-1:0] base;

  // lowest protected quarter index for each code
  always_comb begin
    case (bp_code_e'(bp))
      BP_QUARTER: quarter_idx = 2'b11;
      BP_HALF:    quarter_idx = 2'b10;
      default:    quarter_idx = 2'b00;
    endcase
    base   = {{SHIFT{1'b0}}, quarter_idx} << SHIFT;
    locked = (bp != 2'b00) && (addr >= base);
  end
endmodule

// File: rtl/sr_wp_state.sv
module sr_wp_state
  import sr_wp_pkg::*;
#(
  parameter logic       WPEN_RST = 1'b0,
  parameter logic [1:0] BP_RST   = 2'b00
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_wren,
  input  logic            ev_wrdi,
  input  logic            ev_wr_close,
  input  logic            sr_load,
  input  logic [SR_W-1:0] sr_data,
  output logic            wel,
  output logic [SR_W-1:0] prot_bits
);
  localparam logic [SR_W-1:0] PROT_RST =
    ({{(SR_W-1){1'b0}}, WPEN_RST} << WPEN_BIT) |
    ({{(SR_W-2){1'b0}}, BP_RST} << BP_LO);

  logic            wel_q, wel_d;
  logic [SR_W-1:0] prot_q, prot_d;

  always_comb begin
    wel_d = wel_q;
    if (ev_wr_close)  wel_d = 1'b0;
    else if (ev_wrdi) wel_d = 1'b0;
    else if (ev_wren) wel_d = 1'b1;
  end

  always_comb begin
    prot_d = prot_q;
    if (sr_load) prot_d = sr_data & SR_WR_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wel_q <= 1'b0;
    else        wel_q <= wel_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prot_q <= PROT_RST;
    else if (sr_load) prot_q <= prot_d;
  end

  assign wel       = wel_q;
  assign prot_bits = prot_q;
endmodule

// File: rtl/sr_wp_unit.sv
module sr_wp_unit
  import sr_wp_pkg::*;
#(
  parameter int         ADDR_W   = 11,
  parameter logic       WPEN_RST = 1'b0,
  parameter logic [1:0] BP_RST   = 2'b00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_wren,
  input  logic              ev_wrdi,
  input  logic              ev_wrsr,
  input  logic [7:0]        wrsr_data,
  input  logic              ev_wr_close,
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic              wp_n,
  output logic              mem_wr_ok,
  output logic              sr_wr_ok,
  output logic [7:0]        status_byte
);
  logic [1:0]      rst_sync_q;
  logic            rst_q_n;
  logic            wel;
  logic [SR_W-1:0] prot_bits;
  logic            wpen;
  logic [1:0]      bp;
  logic            blk_locked;
  logic            sr_load;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  assign wpen    = prot_bits[WPEN_BIT];
  assign bp      = prot_bits[BP_HI:BP_LO];
  assign sr_load = ev_wrsr & sr_wr_ok;

  sr_wp_state #(
    .WPEN_RST (WPEN_RST),
    .BP_RST   (BP_RST)
  ) u_state (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .ev_wren     (ev_wren),
    .ev_wrdi     (ev_wrdi),
    .ev_wr_close (ev_wr_close),
    .sr_load     (sr_load),
    .sr_data     (wrsr_data),
    .wel         (wel),
    .prot_bits   (prot_bits)
  );

  sr_wp_range #(
    .ADDR_W (ADDR_W)
  ) u_range (
    .bp     (bp),
    .addr   (byte_addr),
    .locked (blk_locked)
  );

  always_comb begin
    sr_wr_ok    = wel & ~(wpen & ~wp_n);
    mem_wr_ok   = wel & ~blk_locked;
    status_byte = prot_bits | ({{(SR_W-1){1'b0}}, wel} << WEL_BIT);
  end
endmodule

// File: rtl/sr_wp_unit_chk.sv
module sr_wp_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_wren,
  input logic       ev_wrdi,
  input logic       ev_wrsr,
  input logic [2:0] wr_bits,
  input logic       ev_wr_close,
  input logic       wp_n,
  input logic       mem_wr_ok,
  input logic       sr_wr_ok,
  input logic [7:0] status_byte
);
  // R1: fixed positions stay zero
  p_fixed_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (status_byte[6:4] == 3'b000) && !status_byte[0]);

  // R2: set event raises the flag
  p_wel_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wren && !ev_wrdi && !ev_wr_close) |=> status_byte[1]);

  // R3: close of a write frame drops the flag
  p_wel_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_close |=> !status_byte[1]);

  // R5: no memory grant without the flag
  p_mem_needs_wel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !status_byte[1] |-> !mem_wr_ok);

  // R6: rejected status write leaves protection bits alone
  p_wrsr_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wrsr && !sr_wr_ok) |=> $stable({status_byte[7], status_byte[3:2]}));

  // R6: accepted status write loads the data bits
  p_wrsr_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wrsr && sr_wr_ok) |=> ({status_byte[7], status_byte[3:2]} == $past(wr_bits)));

  // R6: pin ignored while protect-enable is clear
  p_pin_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !status_byte[7] |-> (sr_wr_ok == status_byte[1]));

  // R9: full lock
  p_full_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_byte[3:2] == 2'b11 && status_byte[7] && !wp_n) |-> (!mem_wr_ok && !sr_wr_ok));
endmodule

bind sr_wp_unit sr_wp_unit_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .ev_wren     (ev_wren),
  .ev_wrdi     (ev_wrdi),
  .ev_wrsr     (ev_wrsr),
  .wr_bits     ({wrsr_data[7], wrsr_data[3:2]}),
  .ev_wr_close (ev_wr_close),
  .wp_n        (wp_n),
  .mem_wr_ok   (mem_wr_ok),
  .sr_wr_ok    (sr_wr_ok),
  .status_byte (status_byte)
);

// File: tb/sr_wp_unit_test.sv
module sr_wp_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_wren = 1'b0, ev_wrdi = 1'b0, ev_wrsr = 1'b0, ev_wr_close = 1'b0;
  logic [7:0]  wrsr_data = 8'h00;
  logic [10:0] byte_addr = 11'h000;
  logic        wp_n = 1'b1;
  logic        mem_wr_ok, sr_wr_ok;
  logic [7:0]  status_byte;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct packed {
    logic [7:0] st;
    logic       mem;
    logic       sr;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  // bench model of the requirements
  bit       m_wel = 1'b0, m_wpen = 1'b0;
  bit [1:0] m_bp = 2'b00;

  always #5 clk = ~clk;

  sr_wp_unit uut (
    .clk(clk), .rst_n(rst_n), .ev_wren(ev_wren), .ev_wrdi(ev_wrdi),
    .ev_wrsr(ev_wrsr), .wrsr_data(wrsr_data), .ev_wr_close(ev_wr_close),
    .byte_addr(byte_addr), .wp_n(wp_n), .mem_wr_ok(mem_wr_ok),
    .sr_wr_ok(sr_wr_ok), .status_byte(status_byte)
  );

  function automatic bit in_range(input bit [1:0] bp, input bit [10:0] a);
    case (bp)
      2'b01:   return a >= 11'h600;
      2'b10:   return a >= 11'h400;
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and queue the expected result
  task automatic step(input bit wren, input bit wrdi, input bit wrsr, input bit close,
                      input bit [7:0] d, input bit [10:0] a, input bit wp,
                      input string tag);
    exp_t e;
    bit sr_pre;
    @(negedge clk);
    ev_wren = wren; ev_wrdi = wrdi; ev_wrsr = wrsr; ev_wr_close = close;
    wrsr_data = d; byte_addr = a; wp_n = wp;
    sr_pre = m_wel && !(m_wpen && !wp);
    if (wrsr && sr_pre) begin
      m_wpen = d[7];
      m_bp   = d[3:2];
    end
    if (close)     m_wel = 1'b0;
    else if (wrdi) m_wel = 1'b0;
    else if (wren) m_wel = 1'b1;
    e.st  = {m_wpen, 3'b000, m_bp, m_wel, 1'b0};
    e.mem = m_wel && !in_range(m_bp, a);
    e.sr  = m_wel && !(m_wpen && !wp);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input bit [10:0] a, input bit wp, input string tag);
    step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, a, wp, tag);
  endtask

  // monitor: compare after the edge that follows each driven cycle
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, "status_byte", status_byte, e.st);
        check(t, "mem_wr_ok", {7'd0, mem_wr_ok}, {7'd0, e.mem});
        check(t, "sr_wr_ok", {7'd0, sr_wr_ok}, {7'd0, e.sr});
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R7", "status in reset", status_byte, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R7", "status after reset", status_byte, 8'h00);
    check("R2", "wel after reset", {7'd0, sr_wr_ok}, 8'h00);

    idle(11'h000, 1'b1, "R5 no flag no grant");
    step(0,0,1,0, 8'h8C, 11'h000, 1'b1, "R6 wrsr rejected without flag");
    step(1,0,0,0, 8'h00, 11'h7FF, 1'b1, "R2 wren sets flag");
    step(0,0,1,0, 8'hFF, 11'h7FF, 1'b0, "R1 fixed zeros and R2 bit1 ignored");
    step(0,0,0,1, 8'h00, 11'h7FF, 1'b1, "R3 close clears flag");
    step(1,0,0,0, 8'h00, 11'h000, 1'b1, "R2 wren again");
    step(0,0,1,0, 8'h04, 11'h000, 1'b0, "R6 pin locks status when enabled");
    step(0,0,1,0, 8'h04, 11'h000, 1'b1, "R6 pin high allows status write");
    step(0,0,0,1, 8'h00, 11'h000, 1'b1, "R3 close after wrsr");
    step(1,0,0,0, 8'h00, 11'h5FF, 1'b0, "R4 quarter edge 5FF open, R5 pin ignored");
    idle(11'h600, 1'b1, "R4 quarter 600 locked");
    idle(11'h7FF, 1'b1, "R8 top byte locked");
    idle(11'h000, 1'b1, "R8 wrap to 000 granted");
    step(0,1,0,0, 8'h00, 11'h000, 1'b1, "R2 wrdi clears flag");
    step(1,0,0,0, 8'h00, 11'h000, 1'b1, "R2 wren");
    step(0,0,1,0, 8'h08, 11'h000, 1'b1, "R6 load half code");
    step(0,0,0,1, 8'h00, 11'h000, 1'b1, "R3 close");
    step(1,0,0,0, 8'h00, 11'h3FF, 1'b1, "R4 half edge 3FF open");
    idle(11'h400, 1'b1, "R4 half 400 locked");
    step(0,0,1,0, 8'h8C, 11'h400, 1'b1, "R6 load full lock with enable");
    step(0,0,0,1, 8'h00, 11'h000, 1'b1, "R3 close");
    step(1,0,0,0, 8'h00, 11'h000, 1'b0, "R9 full lock memory refused");
    step(0,0,1,0, 8'h00, 11'h123, 1'b0, "R9 full lock status refused");
    idle(11'h7FF, 1'b0, "R9 still locked");
    step(1,0,0,1, 8'h00, 11'h000, 1'b1, "R3 close beats wren");
    step(1,1,0,0, 8'h00, 11'h000, 1'b1, "R3 wrdi beats wren");
    step(1,0,0,0, 8'h00, 11'h000, 1'b1, "R6 pin high unlocks status");
    step(0,0,1,0, 8'h00, 11'h000, 1'b1, "R6 clear protection");
    idle(11'h7FF, 1'b0, "R5 unprotected top byte granted, pin low");

    @(negedge clk);
    ev_wren = 0; ev_wrdi = 0; ev_wrsr = 0; ev_wr_close = 0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule